// File: doc/BRIEF.md
# Serial-Controlled SAR Sampling Sequencer

This block is the digital front end of an eight-channel successive-approximation converter. A host clocks an 8-bit control word into it over a serial link with a chip select, a serial clock (SCLK) and a data input. From that word the block works out which channel to sample and whether the negative side of the sample is a shared common input or the other member of a channel pair. It then drives the track/hold switch and the sampling multiplexer at fixed SCLK edges.

Once the sample is held, the block runs a 12-bit successive-approximation search. It presents a binary-weighted trial code to an external DAC and reads back a comparator bit, deciding one bit per SCLK. It then returns the result to the host, MSB first, on the serial output. Everything runs on a fast system clock `clk`. SCLK is treated as a slow signal on that clock domain, and its high and low phases must each last at least two `clk` cycles.

The serial stream has no back-pressure in either direction. The host sets the pace with SCLK, and the block acts on every SCLK edge it sees while chip select is low. Data flows only while the host keeps clocking. If the host stops, the block waits in place.

Top module: `sar_seq`

## Requirements
- R1: While `cs_n` is low, `din` is sampled on rising SCLK edges, MSB first. In the idle state, a 0 on `din` is ignored. The first 1 is the start bit and is bit 7 of an 8-bit control word.
- R2: Control word layout: bit 7 is the start bit; bit 6 selects the mode (1 = single-ended, 0 = differential); bits 5:3 give the channel number; bits 2:0 are ignored and do not change the outcome.
- R3: `track` rises on the falling SCLK edge after the fifth word bit and falls on the falling edge after the eighth word bit. It is low at all other times.
- R4: From the track edge onward, `pos_ch` equals the channel number. In single-ended mode `neg_com` is 1. In differential mode `neg_com` is 0 and `neg_ch` equals the channel number XOR 1, so the negative side is the other member of the pair 0/1, 2/3, 4/5 or 6/7.
- R5: `hold_neg` (hold node switched to the negative input) rises at the hold edge. It falls after the rising SCLK edge that decides the last result bit. It is never high while `track` is high.
- R6: At the hold edge `dac_code` becomes 0x800. Each later rising SCLK edge does two things. It keeps the current trial bit if `cmp_le` = 1 (DAC level not above the sample) and clears it otherwise. It then sets the next lower bit as the new trial. After 12 such edges, `dac_code` holds the result.
- R7: The result appears on `dout` MSB first, one bit per falling SCLK edge. The first bit comes on the falling edge right after the deciding rising edge. After 12 bits, the next falling edge returns `dout` to 0 and the block to idle. `dout` is 0 at all other times.
- R8: `cs_n` high aborts any transfer. One `clk` later, `track`, `hold_neg`, `dout` and `dac_code` are 0 and the block waits for a new start bit. While `cs_n` is high, SCLK and `din` are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Active-low chip select |
| sclk | input | 1 | Serial clock, slow relative to clk |
| din | input | 1 | Serial control data |
| cmp_le | input | 1 | Comparator: 1 when DAC level does not exceed the sample |
| dout | output | 1 | Serial result data |
| dac_code | output | 12 | Trial code to the binary-weighted DAC |
| pos_ch | output | 3 | Channel switched to the positive sampling input |
| neg_ch | output | 3 | Channel used as the negative input in differential mode |
| neg_com | output | 1 | Negative input is the common input |
| track | output | 1 | Track/hold switch closed (acquiring) |
| hold_neg | output | 1 | Hold node switched to the negative input (converting) |

## Verification
Some properties are checked on every cycle by assertions:
- `track` and `hold_neg` are mutually exclusive.
- `track` only rises after an SCLK fall.
- A differential selection always names the partner channel.
- A trial bit rejected by the comparator is cleared.
- `dout` stays low outside the output phase.
- Chip select forces the idle state.

Only the bench's scenarios can show the rest. This covers:
- the exact SCLK edge on which tracking and hold start;
- that leading zeros and the ignored low word bits change nothing;
- the intermediate codes of the search;
- that the serial result equals the comparator target across every channel, both modes and the extreme codes.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RX   = 2'd1,
    ST_CONV = 2'd2,
    ST_TX   = 2'd3
  } seq_state_t;
endpackage

// File: rtl/sar_seq_edge.sv
module sar_seq_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic sclk,
  output logic rise,
  output logic fall
);
  logic sclk_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sclk_q <= 1'b0;
    else        sclk_q <= sclk;
  end

  assign rise = sclk & ~sclk_q;
  assign fall = ~sclk & sclk_q;
endmodule

// File: rtl/sar_seq_sar.sv
module sar_seq_sar #(
  parameter int RES_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             abort,
  input  logic             start,
  input  logic             step,
  input  logic             cmp_le,
  output logic [RES_W-1:0] code,
  output logic             done
);
  localparam logic [RES_W-1:0] TOP_BIT = {1'b1, {(RES_W-1){1'b0}}};

  logic [RES_W-1:0] trial;
  logic [RES_W-1:0] kept;
  logic             busy;

  // decision on the current trial bit
  always_comb kept = cmp_le ? code : (code & ~trial);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code  <= '0;
      trial <= '0;
      busy  <= 1'b0;
      done  <= 1'b0;
    end else if (abort) begin
      code  <= '0;
      trial <= '0;
      busy  <= 1'b0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start) begin
        code  <= TOP_BIT;
        trial <= TOP_BIT;
        busy  <= 1'b1;
      end else if (busy && step) begin
        code  <= kept | (trial >> 1);
        trial <= trial >> 1;
        if (trial[0]) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end

  // R6
  sar_reject_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && step && !start && !abort && !cmp_le) |=> ((code & $past(trial)) == '0));
endmodule

// File: rtl/sar_seq_ctl.sv
module sar_seq_ctl
  import sar_seq_pkg::*;
#(
  parameter int CW_W  = 8,
  parameter int CH_N  = 8,
  parameter int RES_W = 12,
  localparam int CH_W = $clog2(CH_N)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cs_n,
  input  logic             rise,
  input  logic             fall,
  input  logic             din,
  input  logic             sar_done,
  input  logic [RES_W-1:0] sar_code,
  output logic             sar_start,
  output logic             track,
  output logic             hold_neg,
  output logic [CH_W-1:0]  pos_ch,
  output logic [CH_W-1:0]  neg_ch,
  output logic             neg_com,
  output logic             dout
);
  // start bit, mode bit, then the channel field: all known after TRACK_AT bits
  localparam int TRACK_AT = CH_W + 2;
  localparam int CNT_MAX  = (CW_W > RES_W) ? CW_W : RES_W;
  localparam int CNT_W    = $clog2(CNT_MAX + 1);

  seq_state_t       st;
  logic [CH_W:0]    sr;   // mode bit above channel field
  logic [RES_W-1:0] txsr;
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      sr        <= '0;
      txsr      <= '0;
      cnt       <= '0;
      sar_start <= 1'b0;
      track     <= 1'b0;
      hold_neg  <= 1'b0;
      pos_ch    <= '0;
      neg_ch    <= '0;
      neg_com   <= 1'b0;
      dout      <= 1'b0;
    end else begin
      sar_start <= 1'b0;
      if (cs_n) begin
        st       <= ST_IDLE;
        sr       <= '0;
        cnt      <= '0;
        track    <= 1'b0;
        hold_neg <= 1'b0;
        dout     <= 1'b0;
      end else begin
        case (st)
          ST_IDLE: begin
            if (rise && din) begin
              sr  <= '0;
              cnt <= CNT_W'(1);
              st  <= ST_RX;
            end
          end
          ST_RX: begin
            if (rise) begin
              sr  <= {sr[CH_W-1:0], din};
              cnt <= cnt + 1'b1;
            end else if (fall && cnt == CNT_W'(TRACK_AT)) begin
              track  <= 1'b1;
              pos_ch <= sr[CH_W-1:0];
              if (sr[CH_W]) begin
                neg_com <= 1'b1;
                neg_ch  <= '0;
              end else begin
                neg_com <= 1'b0;
                neg_ch  <= sr[CH_W-1:0] ^ CH_W'(1);
              end
            end else if (fall && cnt == CNT_W'(CW_W)) begin
              track     <= 1'b0;
              hold_neg  <= 1'b1;
              sar_start <= 1'b1;
              cnt       <= '0;
              st        <= ST_CONV;
            end
          end
          ST_CONV: begin
            if (sar_done) begin
              hold_neg <= 1'b0;
              txsr     <= sar_code;
              cnt      <= '0;
              st       <= ST_TX;
            end
          end
          default: begin
            if (fall) begin
              if (cnt == CNT_W'(RES_W)) begin
                dout <= 1'b0;
                cnt  <= '0;
                st   <= ST_IDLE;
              end else begin
                dout <= txsr[RES_W-1];
                txsr <= {txsr[RES_W-2:0], 1'b0};
                cnt  <= cnt + 1'b1;
              end
            end
          end
        endcase
      end
    end
  end

  // R3
  track_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(track) |-> $past(fall));

  // R5
  track_hold_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(track && hold_neg));

  // R4
  diff_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((track || hold_neg) && !neg_com) |-> (neg_ch == (pos_ch ^ CH_W'(1))));

  // R7
  dout_idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st != ST_TX) |-> !dout);

  // R8
  cs_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |=> (st == ST_IDLE && !track && !hold_neg && !dout));
endmodule

// File: rtl/sar_seq.sv
module sar_seq #(
  parameter int RES_W = 12,
  parameter int CH_N  = 8,
  parameter int CW_W  = 8,
  localparam int CH_W = $clog2(CH_N)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cs_n,
  input  logic             sclk,
  input  logic             din,
  input  logic             cmp_le,
  output logic             dout,
  output logic [RES_W-1:0] dac_code,
  output logic [CH_W-1:0]  pos_ch,
  output logic [CH_W-1:0]  neg_ch,
  output logic             neg_com,
  output logic             track,
  output logic             hold_neg
);
  logic rise, fall, sar_start, sar_done;

  sar_seq_edge u_edge (
    .clk  (clk),
    .rst_n(rst_n),
    .sclk (sclk),
    .rise (rise),
    .fall (fall)
  );

  sar_seq_ctl #(
    .CW_W (CW_W),
    .CH_N (CH_N),
    .RES_W(RES_W)
  ) u_ctl (
    .clk      (clk),
    .rst_n    (rst_n),
    .cs_n     (cs_n),
    .rise     (rise),
    .fall     (fall),
    .din      (din),
    .sar_done (sar_done),
    .sar_code (dac_code),
    .sar_start(sar_start),
    .track    (track),
    .hold_neg (hold_neg),
    .pos_ch   (pos_ch),
    .neg_ch   (neg_ch),
    .neg_com  (neg_com),
    .dout     (dout)
  );

  sar_seq_sar #(
    .RES_W(RES_W)
  ) u_sar (
    .clk   (clk),
    .rst_n (rst_n),
    .abort (cs_n),
    .start (sar_start),
    .step  (rise),
    .cmp_le(cmp_le),
    .code  (dac_code),
    .done  (sar_done)
  );
endmodule

// File: tb/sar_seq_tb.sv
module sar_seq_tb;
  localparam int CLK_P = 10;
  localparam int PH    = 4;
  localparam int RW    = 12;

  logic clk = 1'b0, rst_n = 1'b0, cs_n = 1'b1, sclk = 1'b0, din = 1'b0;
  logic [RW-1:0] target = '0;
  logic          cmp_le, dout, neg_com, track, hold_neg;
  logic [RW-1:0] dac_code;
  logic [2:0]    pos_ch, neg_ch;
  int n_chk = 0, n_bad = 0;

  assign cmp_le = (dac_code <= target);

  sar_seq u_dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .din(din),
    .cmp_le(cmp_le), .dout(dout), .dac_code(dac_code), .pos_ch(pos_ch),
    .neg_ch(neg_ch), .neg_com(neg_com), .track(track), .hold_neg(hold_neg)
  );

  always #(CLK_P/2) clk = ~clk;

  task automatic check(input string msg, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", msg, act, exp);
    end
  endtask

  task automatic tick(input logic d);
    din = d;
    @(negedge clk); sclk = 1'b1;
    repeat (PH) @(negedge clk);
    sclk = 1'b0;
    repeat (PH) @(negedge clk);
  endtask

  task automatic run(input int ch, input int se, input int lead, input int low, input int tgt, input bit keep);
    logic [7:0]    w;
    logic [RW-1:0] got;
    int            e;
    target = RW'(tgt);
    w = {1'b1, 1'(se), 3'(ch), 3'(low)};
    got = '0;
    cs_n = 1'b0;
    @(negedge clk);
    for (int i = 0; i < lead; i++) begin
      tick(1'b0);
      check("R1 leading zero ignored", track, 0);
    end
    for (int i = 7; i >= 0; i--) begin
      tick(w[i]);
      if (i == 4) check("R3 no track before fifth bit", track, 0);
      if (i == 3) begin
        check("R3 track after fifth bit", track, 1);
        check("R4 pos_ch", pos_ch, ch);
        check("R4 neg_com", neg_com, se);
        if (se == 0) check("R4 neg_ch partner", neg_ch, ch ^ 1);
      end
      if (i == 0) begin
        check("R3 hold after eighth bit", track, 0);
        check("R5 hold_neg at hold", hold_neg, 1);
        check("R6 first trial code", dac_code, 32'h800);
      end
    end
    for (int j = 1; j <= RW; j++) begin
      tick(1'b0);
      e = (tgt & ~((1 << (RW - j)) - 1)) | ((j < RW) ? (1 << (RW - 1 - j)) : 0);
      check("R6 search code", dac_code, e);
      check("R5 hold_neg during conversion", hold_neg, (j < RW) ? 1 : 0);
    end
    got[RW-1] = dout;
    for (int b = RW - 2; b >= 0; b--) begin
      tick(1'b0);
      got[b] = dout;
    end
    check("R7 R2 serial result", got, tgt);
    tick(1'b0);
    check("R7 dout low after last bit", dout, 0);
    if (!keep) begin
      cs_n = 1'b1;
      repeat (2) @(negedge clk);
    end
  endtask

  task automatic abort_at(input int n);
    logic [7:0] w;
    w = 8'hC0;
    target = '1;
    cs_n = 1'b0;
    @(negedge clk);
    for (int k = 0; k < n; k++) tick(k < 8 ? w[7-k] : 1'b0);
    cs_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R8 abort track", track, 0);
    check("R8 abort hold_neg", hold_neg, 0);
    check("R8 abort dout", dout, 0);
    check("R8 abort dac_code", dac_code, 0);
    for (int k = 0; k < 6; k++) tick(1'b1);
    check("R8 sclk ignored while deselected", track, 0);
  endtask

  task automatic summary;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R3 track low at reset", track, 0);
    check("R7 dout low at reset", dout, 0);
    check("R5 hold_neg low at reset", hold_neg, 0);
    for (int ch = 0; ch < 8; ch++)
      for (int se = 0; se < 2; se++)
        run(ch, se, ch % 3, (ch * 3 + se * 5) % 8, (ch * 613 + se * 1999 + 37) % 4096, 1'b0);
    run(5, 0, 0, 7, 0, 1'b1);
    run(2, 1, 0, 0, 4095, 1'b1);
    run(7, 0, 2, 5, 2048, 1'b0);
    run(0, 1, 1, 2, 2047, 1'b0);
    run(1, 0, 0, 1, 1, 1'b0);
    abort_at(6);
    abort_at(13);
    abort_at(22);
    run(3, 0, 0, 6, 1234, 1'b0);
    summary();
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired act=running exp=finished");
    summary();
    $finish;
  end
endmodule